// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block drives a 10-bit successive-approximation conversion on one of three single-ended analog inputs. Software reaches it through a small word-addressed register bus with four registers: result, status, control and start delay. A control write with the power bit set while the block is idle does four things: it powers the converter, picks the input, waits a programmable number of clock cycles for the analog front end to settle, and then searches for the code. The search works from the most significant bit down. Each trial code goes to the DAC and the external comparator is read one cycle later.

When the last bit is settled, the code is stored in the result register, the busy flag drops and a sticky completion flag is set. The completion flag can be routed to an interrupt line. Software writes zero to the control register to acknowledge the interrupt and power the converter down. The same write aborts a conversion that is still running.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset all four registers read zero, and `irq`, `pwr_on` and `dac_code` are zero.
- R2: Registers are selected by `bus_addr[3:2]`: 0 = result, 1 = status, 2 = control, 3 = delay. Reads are combinational. Unused bits read zero: result 31:10, status 31:1, control 4 and 31:7, delay 31:6. Writes to the result and status registers have no effect.
- R3: A control write with bit 3 set while idle sets `pwr_on`. It also sets status bit 0 (busy) from the next edge, for exactly D+21 cycles, where D is the delay register value.
- R4: The search is MSB first. A trial bit is kept when `cmp_hi` is 1 (input at or above the trial code). For an input whose comparator threshold is T, result bits 9:0 read T.
- R5: Control bits 2:0 choose the input. `mux_ch` equals the code for codes 0 to 2 and is 0 for codes 3 to 7.
- R6: A finished conversion sets control bit 6. `irq` is high exactly when bit 6 and control bit 5 are both set.
- R7: A control write of zero clears bits 6, 5, 3 and 2:0 and drops `pwr_on`. If the block is busy, busy is low from the next edge and the result register keeps its old value.
- R8: A non-zero control write while busy is ignored: the control readback is unchanged and the conversion finishes with its original input.
- R9: The delay register keeps only bits 5:0. D=0 gives 21 busy cycles and D=63 gives 84.
- R10: `dac_code` is zero whenever the block is not busy.
- R11: A control write without bit 3 while idle stores bits 5 and 2:0, clears bit 6, and starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | converter clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_en | input | 1 | bus access strobe |
| bus_wr | input | 1 | write when high, read when low |
| bus_addr | input | 4 | byte address of the register |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data (combinational) |
| cmp_hi | input | 1 | comparator: input at or above the DAC level |
| dac_code | output | 10 | trial code for the DAC |
| mux_ch | output | 2 | analog input selected |
| pwr_on | output | 1 | converter power enable |
| irq | output | 1 | interrupt request |

## Verification
A wrong bit decision in the sequencer shows up in the result register at the end of the conversion, at the latest 21+D cycles after the start. A wrong bit in the upper part of the search also pulls every later trial code away from the comparator model's threshold. A fault in the delay or step counting moves the fall of the busy flag by whole cycles, and the bench counts cycles from the start write to catch this. A state machine that fails to return to idle after an abort leaves busy set on the very next cycle. A lost completion leaves control bit 6 and `irq` low once busy has dropped.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // word index of each register (bus_addr[3:2])
  localparam int unsigned RIX_RESULT = 0;
  localparam int unsigned RIX_STATUS = 1;
  localparam int unsigned RIX_CTRL   = 2;
  localparam int unsigned RIX_DELAY  = 3;

  // control register bit positions
  localparam int unsigned CB_PWR  = 3;
  localparam int unsigned CB_IE   = 5;
  localparam int unsigned CB_DONE = 6;
  localparam int unsigned CH_FW   = 3;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_WAIT  = 2'd1,
    S_TRY   = 2'd2,
    S_JUDGE = 2'd3
  } seq_st_t;
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int unsigned NBITS = 10,
  parameter int unsigned DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             cmp_hi_i,
  output logic             busy_o,
  output logic [NBITS-1:0] dac_o,
  output logic             done_o,
  output logic [NBITS-1:0] result_o
);
  import sar_pkg::*;

  localparam int unsigned IW = (NBITS > 1) ? $clog2(NBITS) : 1;

  // code under test: bits already kept plus the bit being tried
  function automatic logic [NBITS-1:0] trial_code(input logic [NBITS-1:0] kept,
                                                  input logic [IW-1:0]    idx);
    trial_code = kept | (NBITS'(1) << idx);
  endfunction

  // outcome of one step: keep the trial bit only when input >= trial level
  function automatic logic [NBITS-1:0] decide(input logic [NBITS-1:0] kept,
                                              input logic [IW-1:0]    idx,
                                              input logic             hi);
    decide = hi ? trial_code(kept, idx) : kept;
  endfunction

  seq_st_t          st_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly_q;
  logic [IW-1:0]    bidx_q;
  logic [NBITS-1:0] kept_q;
  logic             last_step;

  assign last_step = (st_q == S_JUDGE) && (bidx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      dly_q  <= '0;
      bidx_q <= '0;
      kept_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (start_i) begin
            st_q   <= S_WAIT;
            cnt_q  <= '0;
            dly_q  <= dly_i;
            kept_q <= '0;
          end
        end
        S_WAIT: begin
          if (abort_i) begin
            st_q <= S_IDLE;
          end else if (cnt_q == dly_q) begin
            st_q   <= S_TRY;
            bidx_q <= IW'(NBITS - 1);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_TRY: begin
          st_q <= abort_i ? S_IDLE : S_JUDGE;
        end
        S_JUDGE: begin
          if (abort_i) begin
            st_q <= S_IDLE;
          end else begin
            kept_q <= decide(kept_q, bidx_q, cmp_hi_i);
            if (bidx_q == '0) begin
              st_q <= S_IDLE;
            end else begin
              bidx_q <= bidx_q - 1'b1;
              st_q   <= S_TRY;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q != S_IDLE);
  assign dac_o    = ((st_q == S_TRY) || (st_q == S_JUDGE)) ? trial_code(kept_q, bidx_q) : '0;
  assign done_o   = last_step && !abort_i;
  assign result_o = decide(kept_q, bidx_q, cmp_hi_i);
endmodule

// File: rtl/sar_chmux.sv
module sar_chmux #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CH_FW  = 3,
  parameter int unsigned SEL_W  = 2
) (
  input  logic [CH_FW-1:0] ch_i,
  output logic [SEL_W-1:0] sel_o
);
  // codes beyond the last input fall back to input 0
  function automatic logic [SEL_W-1:0] map_channel(input logic [CH_FW-1:0] code);
    if (int'(code) < int'(NUM_CH)) map_channel = SEL_W'(code);
    else                           map_channel = '0;
  endfunction

  assign sel_o = map_channel(ch_i);
endmodule

// File: rtl/sar_regs.sv
module sar_regs #(
  parameter int unsigned NBITS = 10,
  parameter int unsigned DLY_W = 6,
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic [NBITS-1:0] result_i,
  output logic [2:0]       ch_o,
  output logic             ie_o,
  output logic             pwr_o,
  output logic             ist_o,
  output logic [DLY_W-1:0] dly_o,
  output logic             start_o,
  output logic             abort_o
);
  import sar_pkg::*;

  logic [NBITS-1:0] res_q;
  logic [2:0]       ch_q;
  logic             ie_q, pwr_q, ist_q;
  logic [DLY_W-1:0] dly_q;
  logic [1:0]       widx;
  logic             wr_ctrl, wr_dly, wzero, accept;
  logic             unused_addr_lsb;

  assign widx            = bus_addr[3:2];
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign wr_ctrl = bus_en && bus_wr && (widx == 2'(RIX_CTRL));
  assign wr_dly  = bus_en && bus_wr && (widx == 2'(RIX_DELAY));
  assign wzero   = (bus_wdata == '0);
  assign accept  = wr_ctrl && !busy_i;
  assign start_o = accept && bus_wdata[CB_PWR];
  assign abort_o = wr_ctrl && busy_i && wzero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ch_q  <= '0;
      ie_q  <= 1'b0;
      pwr_q <= 1'b0;
      ist_q <= 1'b0;
      dly_q <= '0;
    end else begin
      if (wr_dly) dly_q <= bus_wdata[DLY_W-1:0];
      if (accept || abort_o) begin
        ch_q  <= bus_wdata[CH_FW-1:0];
        ie_q  <= bus_wdata[CB_IE];
        pwr_q <= bus_wdata[CB_PWR];
        ist_q <= 1'b0;
      end else if (done_i) begin
        ist_q <= 1'b1;
        res_q <= result_i;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (widx)
      2'(RIX_RESULT): bus_rdata[NBITS-1:0] = res_q;
      2'(RIX_STATUS): bus_rdata[0]         = busy_i;
      2'(RIX_CTRL): begin
        bus_rdata[CH_FW-1:0] = ch_q;
        bus_rdata[CB_PWR]    = pwr_q;
        bus_rdata[CB_IE]     = ie_q;
        bus_rdata[CB_DONE]   = ist_q;
      end
      default:        bus_rdata[DLY_W-1:0] = dly_q;
    endcase
  end

  assign ch_o  = ch_q;
  assign ie_o  = ie_q;
  assign pwr_o = pwr_q;
  assign ist_o = ist_q;
  assign dly_o = dly_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int unsigned NBITS  = 10,
  parameter int unsigned DLY_W  = 6,
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned AW     = 4,
  parameter int unsigned DW     = 32,
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             cmp_hi,
  output logic [NBITS-1:0] dac_code,
  output logic [SEL_W-1:0] mux_ch,
  output logic             pwr_on,
  output logic             irq
);
  // internal events, named for the checker
  logic             busy;
  logic             conv_done;
  logic             start_req;
  logic             abort_req;
  logic             irq_st;
  logic             irq_en;
  logic [2:0]       ch_q;
  logic [DLY_W-1:0] dly_q;
  logic [NBITS-1:0] result;

  sar_regs #(.NBITS(NBITS), .DLY_W(DLY_W), .AW(AW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy_i   (busy),
    .done_i   (conv_done),
    .result_i (result),
    .ch_o     (ch_q),
    .ie_o     (irq_en),
    .pwr_o    (pwr_on),
    .ist_o    (irq_st),
    .dly_o    (dly_q),
    .start_o  (start_req),
    .abort_o  (abort_req)
  );

  sar_seq #(.NBITS(NBITS), .DLY_W(DLY_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_req),
    .abort_i  (abort_req),
    .dly_i    (dly_q),
    .cmp_hi_i (cmp_hi),
    .busy_o   (busy),
    .dac_o    (dac_code),
    .done_o   (conv_done),
    .result_o (result)
  );

  sar_chmux #(.NUM_CH(NUM_CH), .CH_FW(3), .SEL_W(SEL_W)) u_mux (
    .ch_i (ch_q),
    .sel_o(mux_ch)
  );

  assign irq = irq_st & irq_en;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int unsigned NBITS  = 10,
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned SEL_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             pwr_on,
  input logic [NBITS-1:0] dac_code,
  input logic [SEL_W-1:0] mux_ch,
  input logic             conv_done,
  input logic             abort_req,
  input logic             irq_st,
  input logic [2:0]       ch_q
);
  // R3
  busy_has_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pwr_on);

  // R6
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (irq_st && !busy));

  // R10
  idle_dac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_code == '0));

  // R5
  mux_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mux_ch) < int'(NUM_CH));

  // R7
  abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (!busy && !pwr_on && !irq_st));

  // R8
  busy_ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort_req) |=> $stable(ch_q));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.NBITS(NBITS), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .pwr_on   (pwr_on),
  .dac_code (dac_code),
  .mux_ch   (mux_ch),
  .conv_done(conv_done),
  .abort_req(abort_req),
  .irq_st   (irq_st),
  .ch_q     (ch_q)
);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmp_hi;
  logic [9:0]  dac_code;
  logic [1:0]  mux_ch;
  logic        pwr_on;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [9:0] target [3];

  always #5 clk = ~clk;

  // comparator model: input at or above the trial level
  assign cmp_hi = (target[mux_ch] >= dac_code);

  sar_adc_ctrl i_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_hi(cmp_hi), .dac_code(dac_code), .mux_ch(mux_ch),
    .pwr_on(pwr_on), .irq(irq)
  );

  localparam logic [3:0] A_RES = 4'h0, A_STA = 4'h4, A_CTL = 4'h8, A_DLY = 4'hC;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // counts busy cycles after a start write, returns at first idle negedge
  task automatic busy_cycles(output int n);
    logic [31:0] s;
    n = 0;
    rd(A_STA, s);
    while (s[0] === 1'b1 && n < 300) begin
      n++;
      @(negedge clk);
      rd(A_STA, s);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_RES, v); check("R1", "result", v, 0);
    rd(A_STA, v); check("R1", "status", v, 0);
    rd(A_CTL, v); check("R1", "ctrl", v, 0);
    rd(A_DLY, v); check("R1", "delay", v, 0);
    check("R1", "irq/pwr/dac", {irq, pwr_on, dac_code}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(A_DLY, 32'hFFFF_FFC5);
    rd(A_DLY, v); check("R9", "delay width", v, 32'h05);
    wr(A_RES, 32'hFFFF_FFFF);
    rd(A_RES, v); check("R2", "result not writable", v, 0);
    wr(A_STA, 32'hFFFF_FFFF);
    rd(A_STA, v); check("R2", "status not writable", v, 0);
  endtask

  task automatic t_convert(input logic [2:0] ch, input logic ie, input logic [5:0] d,
                           input logic [9:0] exp_res, input logic [1:0] exp_sel);
    logic [31:0] v;
    int n;
    wr(A_DLY, {26'd0, d});
    wr(A_CTL, {26'd0, ie, 1'b0, 1'b1, ch});
    check("R3", "pwr_on at start", {31'd0, pwr_on}, 1);
    check("R5", "mux_ch", {30'd0, mux_ch}, {30'd0, exp_sel});
    busy_cycles(n);
    check("R3", "busy cycle count", n, int'(d) + 21);
    rd(A_RES, v); check("R4", "result", v, {22'd0, exp_res});
    rd(A_CTL, v); check("R6", "ctrl after done", v, {25'd0, 1'b1, ie, 1'b0, 1'b1, ch});
    check("R6", "irq", {31'd0, irq}, {31'd0, ie});
    check("R10", "dac idle", {22'd0, dac_code}, 0);
  endtask

  task automatic t_clear(input logic [9:0] keep);
    logic [31:0] v;
    wr(A_CTL, 32'h0);
    rd(A_CTL, v); check("R7", "ctrl cleared", v, 0);
    check("R7", "irq/pwr off", {irq, pwr_on}, 0);
    rd(A_RES, v); check("R7", "result kept", v, {22'd0, keep});
  endtask

  task automatic t_ignore_busy;
    logic [31:0] v;
    int n;
    wr(A_DLY, 32'd4);
    wr(A_CTL, 32'h29);
    repeat (3) @(negedge clk);
    wr(A_CTL, 32'h2A);
    rd(A_CTL, v); check("R8", "ctrl unchanged while busy", v, 32'h29);
    check("R8", "mux unchanged", {30'd0, mux_ch}, 1);
    busy_cycles(n);
    rd(A_RES, v); check("R8", "result of original input", v, {22'd0, target[1]});
  endtask

  task automatic t_abort(input logic [9:0] keep);
    logic [31:0] v;
    wr(A_DLY, 32'd2);
    wr(A_CTL, 32'h2A);
    repeat (6) @(negedge clk);
    rd(A_STA, v); check("R3", "busy mid-conversion", v, 1);
    wr(A_CTL, 32'h0);
    rd(A_STA, v); check("R7", "busy after abort", v, 0);
    check("R7", "pwr/irq after abort", {pwr_on, irq}, 0);
    rd(A_RES, v); check("R7", "result after abort", v, {22'd0, keep});
    repeat (30) @(negedge clk);
    rd(A_CTL, v); check("R7", "no completion after abort", v, 0);
  endtask

  task automatic t_no_power;
    logic [31:0] v;
    wr(A_CTL, 32'h22);
    repeat (5) @(negedge clk);
    rd(A_STA, v); check("R11", "no busy", v, 0);
    rd(A_CTL, v); check("R11", "ctrl stored", v, 32'h22);
    check("R11", "pwr off", {31'd0, pwr_on}, 0);
    check("R2", "bit 4 reads zero", {31'd0, v[4]}, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    target[0] = 10'h13C; target[1] = 10'h2A5; target[2] = 10'h3FF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_convert(3'd1, 1'b1, 6'd8, 10'h2A5, 2'd1);
    t_clear(10'h2A5);
    t_convert(3'd2, 1'b0, 6'd0, 10'h3FF, 2'd2);
    target[0] = 10'h000;
    t_convert(3'd0, 1'b1, 6'd63, 10'h000, 2'd0);
    t_clear(10'h000);
    target[0] = 10'h155;
    t_convert(3'd5, 1'b1, 6'd3, 10'h155, 2'd0);
    t_clear(10'h155);
    t_ignore_busy();
    t_clear(target[1]);
    t_abort(target[1]);
    t_no_power();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule